// File: doc/BRIEF.md
# Activity Tag Rewriter for Loop and Call Control

This unit sits in the execute path of a tagged-token dataflow processor. It handles the control instructions that change the context a token belongs to. Every token carries a data value and an activity tag. The tag is a bounded stack of context entries plus a count of how many entries are live. Each entry pairs an iteration number with a key. The key is a code-block number for a loop, or the address of the calling instruction for a procedure invocation.

For each token the unit applies one operation to the tag:
- open a loop or call context, which pushes a fresh entry;
- close a context, which pops the top entry;
- advance the top entry's iteration number by one;
- set the top entry's iteration number back to one.

The data value is never altered. Because the iteration number and the nested keys are part of the tag, many iterations and many procedure instances can be in flight at once without their operands being confused by the matching logic downstream.

A tag that would grow beyond the maximum depth, shrink below one entry, or that arrives with an illegal depth count is not forwarded. Instead the unit raises an error pulse. Input and output are valid/ready streams with a single output register.

Top module: `tagu_top`

## Requirements
- R1: After reset, out_valid and err are 0 and in_ready is 1.
- R2: Opcode 0 (loop open) writes a new entry into slot in_depth with iteration 1 and key in_key, and raises the depth by one. The stack is packed as slot i at bits [i*(ITER_W+KEY_W) +: ITER_W+KEY_W], and each entry is {iteration, key} with the iteration in the upper ITER_W bits. All other slots pass unchanged.
- R3: Opcode 4 (call) pushes exactly as opcode 0 does, with in_key being the calling instruction's address.
- R4: Opcodes 1 (loop close) and 5 (return) pop the top entry: depth drops by one and slot in_depth-1 becomes all zeros. All other slots are unchanged.
- R5: Opcode 2 (step) adds 1 modulo 2^ITER_W to the iteration number of slot in_depth-1. That slot's key, all other slots and the depth stay unchanged.
- R6: Opcode 3 (restart) sets the iteration number of slot in_depth-1 to 1. Its key, all other slots and the depth stay unchanged.
- R7: out_data always equals the accepted in_data. Opcodes 6 and 7 forward the whole token unchanged.
- R8: An accepted token is dropped when in_depth is 0 or above MAX_DEPTH, when a push sees in_depth == MAX_DEPTH, or when a pop sees in_depth == 1. In that case err is 1 for exactly the cycle after acceptance and out_valid stays 0.
- R9: in_ready equals !out_valid || out_ready. While out_valid is 1 and out_ready is 0, all output fields hold their values.
- R10: A token accepted at a clock edge is presented on the outputs with out_valid=1 right after that edge, and out_valid clears after an edge where out_ready is 1 and no new token is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Unit can accept a token |
| in_op | input | 3 | Tag operation code |
| in_key | input | KEY_W | Code-block number or caller address for pushes |
| in_data | input | DATA_W | Token data value |
| in_stack | input | MAX_DEPTH*(ITER_W+KEY_W) | Packed tag stack |
| in_depth | input | DEPTH_W | Live entry count of the input tag |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Downstream accepts the output token |
| out_data | output | DATA_W | Forwarded data value |
| out_stack | output | MAX_DEPTH*(ITER_W+KEY_W) | Rewritten tag stack |
| out_depth | output | DEPTH_W | Rewritten entry count |
| err | output | 1 | One-cycle pulse when a token is dropped |

## Verification
A wrong slot index or depth update shows up at the port on the very next edge after acceptance. It appears as a modified slot other than the top, a vacated slot that is not zeroed, or an out_depth off by one. A faulty guard on the depth limits shows up in the same cycle, either as a forwarded token where err should pulse or as err without a drop. Register or handshake faults show up as output fields that change during a stall, or as in_ready asserted while a token is still held.

// File: rtl/tagu_pkg.sv
package tagu_pkg;

  localparam logic [2:0] OP_LOOP_OPEN  = 3'd0;
  localparam logic [2:0] OP_LOOP_CLOSE = 3'd1;
  localparam logic [2:0] OP_STEP       = 3'd2;
  localparam logic [2:0] OP_RESTART    = 3'd3;
  localparam logic [2:0] OP_CALL       = 3'd4;
  localparam logic [2:0] OP_RETURN     = 3'd5;

  function automatic logic op_pushes(input logic [2:0] op);
    return (op == OP_LOOP_OPEN) || (op == OP_CALL);
  endfunction

  function automatic logic op_pops(input logic [2:0] op);
    return (op == OP_LOOP_CLOSE) || (op == OP_RETURN);
  endfunction

  function automatic logic op_steps(input logic [2:0] op);
    return op == OP_STEP;
  endfunction

  function automatic logic op_restarts(input logic [2:0] op);
    return op == OP_RESTART;
  endfunction

endpackage

// File: rtl/tagu_rewrite.sv
module tagu_rewrite
  import tagu_pkg::*;
#(
  parameter int ITER_W    = 8,
  parameter int KEY_W     = 8,
  parameter int MAX_DEPTH = 8,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic [2:0]                          op,
  input  logic [KEY_W-1:0]                    key,
  input  logic [MAX_DEPTH*(ITER_W+KEY_W)-1:0] stack_i,
  input  logic [DEPTH_W-1:0]                  depth_i,
  output logic [MAX_DEPTH*(ITER_W+KEY_W)-1:0] stack_o,
  output logic [DEPTH_W-1:0]                  depth_o,
  output logic                                bad
);
  localparam int EW = ITER_W + KEY_W;

  function automatic logic [ITER_W-1:0] iter_next(input logic [ITER_W-1:0] n);
    return n + ITER_W'(1);
  endfunction

  function automatic logic [ITER_W-1:0] iter_first();
    return ITER_W'(1);
  endfunction

  logic push, pop, step, restart, depth_ok;
  logic [DEPTH_W-1:0] top_idx;

  assign push     = op_pushes(op);
  assign pop      = op_pops(op);
  assign step     = op_steps(op);
  assign restart  = op_restarts(op);
  assign depth_ok = (depth_i != '0) && (depth_i <= DEPTH_W'(MAX_DEPTH));
  assign top_idx  = depth_i - DEPTH_W'(1);

  assign bad = !depth_ok
             || (push && depth_i == DEPTH_W'(MAX_DEPTH))
             || (pop  && depth_i == DEPTH_W'(1));

  assign depth_o = push ? depth_i + DEPTH_W'(1)
                 : pop  ? depth_i - DEPTH_W'(1)
                 : depth_i;

  for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_slot
    logic [EW-1:0] slot_in, slot_out;
    assign slot_in = stack_i[i*EW +: EW];
    always_comb begin
      slot_out = slot_in;
      if (push && depth_i == DEPTH_W'(i))
        slot_out = {iter_first(), key};
      else if (pop && top_idx == DEPTH_W'(i))
        slot_out = '0;
      else if (step && top_idx == DEPTH_W'(i))
        slot_out[EW-1:KEY_W] = iter_next(slot_in[EW-1:KEY_W]);
      else if (restart && top_idx == DEPTH_W'(i))
        slot_out[EW-1:KEY_W] = iter_first();
    end
    assign stack_o[i*EW +: EW] = slot_out;
  end

endmodule

// File: rtl/tagu_outreg.sv
module tagu_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        q     <= d;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(q)));

endmodule

// File: rtl/tagu_top.sv
module tagu_top
  import tagu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ITER_W    = 8,
  parameter int KEY_W     = 8,
  parameter int MAX_DEPTH = 8,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [2:0]                          in_op,
  input  logic [KEY_W-1:0]                    in_key,
  input  logic [DATA_W-1:0]                   in_data,
  input  logic [MAX_DEPTH*(ITER_W+KEY_W)-1:0] in_stack,
  input  logic [DEPTH_W-1:0]                  in_depth,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [DATA_W-1:0]                   out_data,
  output logic [MAX_DEPTH*(ITER_W+KEY_W)-1:0] out_stack,
  output logic [DEPTH_W-1:0]                  out_depth,
  output logic                                err
);
  localparam int SW = MAX_DEPTH * (ITER_W + KEY_W);
  localparam int PW = DATA_W + SW + DEPTH_W;

  logic [SW-1:0]      new_stack;
  logic [DEPTH_W-1:0] new_depth;
  logic               bad;
  logic               in_fire, load_evt, drop_evt;
  logic [PW-1:0]      payload_q;

  tagu_rewrite #(
    .ITER_W(ITER_W), .KEY_W(KEY_W), .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)
  ) u_rewrite (
    .op(in_op), .key(in_key), .stack_i(in_stack), .depth_i(in_depth),
    .stack_o(new_stack), .depth_o(new_depth), .bad(bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign load_evt = in_fire && !bad;
  assign drop_evt = in_fire && bad;

  tagu_outreg #(.W(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load_evt),
    .d({in_data, new_stack, new_depth}),
    .ready(out_ready), .valid(out_valid), .q(payload_q)
  );

  assign {out_data, out_stack, out_depth} = payload_q;

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= drop_evt;
  end

  assert_push_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && op_pushes(in_op)) |=> (out_depth == $past(in_depth) + DEPTH_W'(1)));

  assert_pop_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && op_pops(in_op)) |=> (out_depth == $past(in_depth) - DEPTH_W'(1)));

  assert_data_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (out_valid && out_data == $past(in_data)));

  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (err && !out_valid));

  assert_depth_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_depth != '0 && out_depth <= DEPTH_W'(MAX_DEPTH)));

endmodule

// File: tb/sim_tagu_top.sv
`timescale 1ns/1ps
module sim_tagu_top;
  localparam int DW = 16, IW = 8, KW = 8, MD = 8, DPW = 4;
  localparam int EW = IW + KW;
  localparam int SW = MD * EW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [2:0] in_op = 0;
  logic [KW-1:0] in_key = 0;
  logic [DW-1:0] in_data = 0;
  logic [SW-1:0] in_stack = 0;
  logic [DPW-1:0] in_depth = 0;
  logic in_ready, out_valid, err;
  logic [DW-1:0] out_data;
  logic [SW-1:0] out_stack;
  logic [DPW-1:0] out_depth;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tagu_top #(.DATA_W(DW), .ITER_W(IW), .KEY_W(KW), .MAX_DEPTH(MD), .DEPTH_W(DPW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_key(in_key), .in_data(in_data), .in_stack(in_stack),
    .in_depth(in_depth), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_stack(out_stack), .out_depth(out_depth), .err(err));

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: unpack, edit an entry list, repack.
  task automatic model(input logic [2:0] op, input logic [KW-1:0] key,
                       input logic [SW-1:0] st, input logic [DPW-1:0] dp,
                       output logic [SW-1:0] est, output logic [DPW-1:0] edp, output bit eerr);
    logic [IW-1:0] it [MD];
    logic [KW-1:0] ky [MD];
    int d = int'(dp);
    bit grow = (op == 3'd0 || op == 3'd4);
    bit shrink = (op == 3'd1 || op == 3'd5);
    for (int i = 0; i < MD; i++) begin
      ky[i] = st[i*EW +: KW];
      it[i] = st[i*EW + KW +: IW];
    end
    eerr = (d < 1) || (d > MD) || (grow && d == MD) || (shrink && d == 1);
    edp = dp;
    if (!eerr) begin
      if (grow) begin it[d] = 1; ky[d] = key; edp = DPW'(d + 1); end
      else if (shrink) begin it[d-1] = 0; ky[d-1] = 0; edp = DPW'(d - 1); end
      else if (op == 3'd2) it[d-1] = IW'((int'(it[d-1]) + 1) % (1 << IW));
      else if (op == 3'd3) it[d-1] = 1;
    end
    for (int i = 0; i < MD; i++) est[i*EW +: EW] = {it[i], ky[i]};
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd4: return "R3";
      3'd1, 3'd5: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [KW-1:0] key,
                       input logic [SW-1:0] st, input logic [DPW-1:0] dp, input int stall);
    logic [SW-1:0] est; logic [DPW-1:0] edp; bit eerr;
    logic [DW-1:0] dat = DW'($urandom);
    model(op, key, st, dp, est, edp, eerr);
    @(negedge clk);
    in_op = op; in_key = key; in_stack = st; in_depth = dp; in_data = dat;
    in_valid = 1; out_ready = 0;
    chk(in_ready == 1, "R9", 160'(in_ready), 160'(1));
    @(negedge clk);
    in_valid = 0;
    if (eerr) begin
      chk(err == 1 && out_valid == 0, "R8", 160'({err, out_valid}), 160'(2'b10));
    end else begin
      chk(out_valid == 1 && err == 0, "R10", 160'({out_valid, err}), 160'(2'b10));
      chk(out_stack == est && out_depth == edp, req_of(op),
          160'({out_stack, out_depth}), 160'({est, edp}));
      chk(out_data == dat, "R7", 160'(out_data), 160'(dat));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(out_valid == 1 && in_ready == 0 && out_data == dat && out_stack == est && out_depth == edp,
            "R9", 160'({out_valid, in_ready, out_stack}), 160'({2'b10, est}));
      end
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 0 && err == 0, "R10", 160'({out_valid, err}), 160'(0));
  endtask

  function automatic logic [SW-1:0] rnd_stack();
    logic [SW-1:0] s;
    for (int i = 0; i < SW / 32; i++) s[i*32 +: 32] = $urandom;
    return s;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && err == 0 && in_ready == 1, "R1",
        160'({out_valid, err, in_ready}), 160'(3'b001));
    rst_n = 1;

    // Directed corners
    apply(3'd0, 8'h5A, rnd_stack(), 4'd8, 0);   // R8 push at full depth
    apply(3'd4, 8'hC3, rnd_stack(), 4'd8, 0);   // R8 call at full depth
    apply(3'd1, 8'h00, rnd_stack(), 4'd1, 0);   // R8 pop at depth 1
    apply(3'd5, 8'h00, rnd_stack(), 4'd1, 0);   // R8 return at depth 1
    apply(3'd2, 8'h00, rnd_stack(), 4'd0, 0);   // R8 depth 0
    apply(3'd6, 8'h00, rnd_stack(), 4'd9, 0);   // R8 depth above max
    apply(3'd0, 8'h11, rnd_stack(), 4'd7, 2);   // R2 push into last slot
    apply(3'd4, 8'h22, rnd_stack(), 4'd1, 3);   // R3 call from base
    apply(3'd1, 8'h00, rnd_stack(), 4'd8, 1);   // R4 pop from full
    begin
      logic [SW-1:0] s = rnd_stack();
      s[2*EW + KW +: IW] = 8'hFF;
      apply(3'd2, 8'h00, s, 4'd3, 0);             // R5 iteration wrap
      apply(3'd3, 8'h00, s, 4'd3, 0);             // R6 restart
    end
    apply(3'd7, 8'h77, rnd_stack(), 4'd4, 2);   // R7 pass-through opcode

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      logic [DPW-1:0] d;
      int r = $urandom_range(0, 19);
      d = (r == 0) ? 4'd0 : (r == 1) ? DPW'($urandom_range(9, 15)) : DPW'($urandom_range(1, 8));
      apply(3'($urandom_range(0, 7)), KW'($urandom), rnd_stack(), d, $urandom_range(0, 3));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 160'(0), 160'(1));
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule